// File: doc/BRIEF.md
# Character Grid Cell Locator

This block sits in a pixel pipeline behind a video timing source. For every pixel of a raster scan, it decides whether the pixel lies inside one of the 8x8 character cells of a grid of numbered tiles. When it does, the block reports the tile number, the glyph bit for that pixel and whether that tile is highlighted. A later colour stage uses these three outputs to paint the pixel.

Cells repeat on a pitch of 13 pixels in both directions, with a 5-pixel gap after each 8-pixel cell. Each column holds eight cells, numbered downward, and numbering carries on into the next column. Counters wrap on the pitch, so the block never compares the position against the bounds of each cell. A flat bank of sixteen 64-bit glyph bitmaps supplies the pixel data, and a 76-bit mask marks the highlighted tiles.

Top module: `grid_cell_locator`

## Requirements
- R1: The outputs describe the pixel presented with `pix_valid` two clock cycles earlier. In any cycle whose input two cycles before carried no pixel, all three outputs are 0.
- R2: Horizontal position x counts pixels (`pix_valid` cycles) since the last strobe, starting at 0. Column c (0 to COLS-1) covers X0+c·COL_PITCH ≤ x < X0+c·COL_PITCH+8. Defaults: X0=7, COL_PITCH=13, COLS=10. Either strobe returns x to 0, and a strobe cycle is not a pixel.
- R3: Line number y is 0 after `frame_start` and grows by 1 at each `line_start`. Row r (0 to 7) covers Y0+13·r ≤ y < Y0+13·r+8, with Y0=70.
- R4: Inside column c and row r, `tile_idx` = 8·c + r + 1. On every other pixel, including gap offsets 8 to 12, it is 0.
- R5: `pix_on` is bit 63 − (cx + 8·ry) of glyph entry (`tile_idx` mod 16). Here cx and ry (0 to 7) are the offsets inside the cell, and entry k occupies `glyph_bank[64k+63:64k]`. Bit 63 is therefore the top-left pixel.
- R6: `hl_flag` equals `hl_mask[tile_idx]` inside a cell and is 0 elsewhere.
- R7: A cell whose computed tile number exceeds 75 counts as outside: all three outputs are 0.
- R8: While `rst_n` is low, and after it, until a pixel has passed through, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe before each line after the first |
| frame_start | input | 1 | One-cycle strobe before line 0 |
| pix_valid | input | 1 | A pixel is presented this cycle |
| glyph_bank | input | 1024 | Sixteen 64-bit glyph bitmaps |
| hl_mask | input | 76 | Highlight bit per tile number |
| pix_on | output | 1 | Glyph bit for the pixel |
| tile_idx | output | 7 | Tile number, 0 outside cells |
| hl_flag | output | 1 | Highlight bit of the current tile |

## Verification
The checker assumes that a strobe never shares a cycle with a pixel. It also assumes that `hl_mask` is sampled in the same cycle the result is formed, so a highlight change shows up in the result one cycle later. The bench issues every strobe in a cycle of its own. It changes the glyph bank and the mask only between frames, while the pipeline is drained. Each line is followed by idle cycles, so zero output after the last pixel is observed too.

// File: rtl/grid_cell_locator.sv
module grid_cell_locator #(
  parameter int COLS      = 10,
  parameter int ROWS      = 8,
  parameter int CELL      = 8,
  parameter int COL_PITCH = 13,
  parameter int ROW_PITCH = 13,
  parameter int X0        = 7,
  parameter int Y0        = 70,
  parameter int MAX_TILE  = 75,
  parameter int GLYPHS    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               line_start,
  input  logic                               frame_start,
  input  logic                               pix_valid,
  input  logic [GLYPHS*CELL*CELL-1:0]        glyph_bank,
  input  logic [MAX_TILE:0]                  hl_mask,
  output logic                               pix_on,
  output logic [$clog2(COLS*ROWS+1)-1:0]     tile_idx,
  output logic                               hl_flag
);
  localparam int GW   = CELL * CELL;
  localparam int TW   = $clog2(COLS*ROWS+1);
  localparam int BW   = $clog2(GW);
  localparam int GBW  = $clog2(GLYPHS*GW);
  localparam int HPW  = $clog2(COL_PITCH);
  localparam int VPW  = $clog2(ROW_PITCH);
  localparam int CW   = $clog2(COLS+1);
  localparam int RW   = $clog2(ROWS+1);
  localparam int XLW  = $clog2(X0+2);
  localparam int YLW  = $clog2(Y0+2);
  localparam int XLST = (X0 > 0) ? X0-1 : 0;
  localparam int YLST = (Y0 > 0) ? Y0-1 : 0;
  localparam logic X_IN0 = (X0 == 0);
  localparam logic Y_IN0 = (Y0 == 0);

  logic           h_in, v_in;
  logic [XLW-1:0] h_lead;
  logic [YLW-1:0] v_lead;
  logic [HPW-1:0] hc;
  logic [VPW-1:0] vc;
  logic [CW-1:0]  col;
  logic [RW-1:0]  row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_in <= X_IN0; h_lead <= '0; hc <= '0; col <= '0;
    end else if (line_start || frame_start) begin
      h_in <= X_IN0; h_lead <= '0; hc <= '0; col <= '0;
    end else if (pix_valid) begin
      if (!h_in) begin
        if (h_lead == XLW'(XLST)) h_in <= 1'b1;
        else h_lead <= h_lead + 1'b1;
      end else if (col != CW'(COLS)) begin
        if (hc == HPW'(COL_PITCH-1)) begin
          hc <= '0; col <= col + 1'b1;
        end else hc <= hc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_in <= Y_IN0; v_lead <= '0; vc <= '0; row <= '0;
    end else if (frame_start) begin
      v_in <= Y_IN0; v_lead <= '0; vc <= '0; row <= '0;
    end else if (line_start) begin
      if (!v_in) begin
        if (v_lead == YLW'(YLST)) v_in <= 1'b1;
        else v_lead <= v_lead + 1'b1;
      end else if (row != RW'(ROWS)) begin
        if (vc == VPW'(ROW_PITCH-1)) begin
          vc <= '0; row <= row + 1'b1;
        end else vc <= vc + 1'b1;
      end
    end
  end

  logic          in_x, in_y, in_cell;
  logic [TW-1:0] tile_raw;
  logic [BW-1:0] bit_sel;

  assign in_x     = h_in && (col < CW'(COLS)) && (int'(hc) < CELL);
  assign in_y     = v_in && (row < RW'(ROWS)) && (int'(vc) < CELL);
  assign tile_raw = TW'(int'(col) * ROWS + int'(row) + 1);
  assign in_cell  = in_x && in_y && (int'(tile_raw) <= MAX_TILE);
  assign bit_sel  = BW'(GW - 1 - (int'(hc) + CELL * int'(vc)));

  logic          s1_hit;
  logic [TW-1:0] s1_tile;
  logic [BW-1:0] s1_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_hit <= 1'b0; s1_tile <= '0; s1_bit <= '0;
    end else begin
      s1_hit  <= pix_valid && in_cell;
      s1_tile <= (pix_valid && in_cell) ? tile_raw : '0;
      s1_bit  <= bit_sel;
    end
  end

  logic [GBW-1:0] gpos;
  assign gpos = GBW'((int'(s1_tile) % GLYPHS) * GW + int'(s1_bit));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_on <= 1'b0; tile_idx <= '0; hl_flag <= 1'b0;
    end else begin
      pix_on   <= s1_hit && glyph_bank[gpos];
      tile_idx <= s1_tile;
      hl_flag  <= s1_hit && hl_mask[s1_tile];
    end
  end
endmodule

// File: rtl/grid_cell_locator_chk.sv
module grid_cell_locator_chk #(
  parameter int COLS      = 10,
  parameter int ROWS      = 8,
  parameter int COL_PITCH = 13,
  parameter int MAX_TILE  = 75,
  parameter int HPW       = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           line_start,
  input logic                           frame_start,
  input logic                           pix_valid,
  input logic [MAX_TILE:0]              hl_mask,
  input logic                           pix_on,
  input logic [$clog2(COLS*ROWS+1)-1:0] tile_idx,
  input logic                           hl_flag,
  input logic [HPW-1:0]                 hc
);
  logic pv_d1, pv_d2;
  logic [MAX_TILE:0] hl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_d1 <= 1'b0; pv_d2 <= 1'b0; hl_q <= '0;
    end else begin
      pv_d1 <= pix_valid; pv_d2 <= pv_d1; hl_q <= hl_mask;
    end
  end

  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pv_d2 |-> (!pix_on && tile_idx == '0 && !hl_flag));

  p_strobe_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_valid && (line_start || frame_start)));

  p_pitch_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(hc) < COL_PITCH);

  p_gap_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tile_idx == '0 |-> (!pix_on && !hl_flag));

  p_hl_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tile_idx != '0 && int'(tile_idx) <= MAX_TILE) |-> hl_flag == hl_q[tile_idx]);

  p_tile_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tile_idx) <= MAX_TILE);
endmodule

bind grid_cell_locator grid_cell_locator_chk #(
  .COLS(COLS), .ROWS(ROWS), .COL_PITCH(COL_PITCH), .MAX_TILE(MAX_TILE), .HPW(HPW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
  .pix_valid(pix_valid), .hl_mask(hl_mask), .pix_on(pix_on), .tile_idx(tile_idx),
  .hl_flag(hl_flag), .hc(hc)
);

// File: tb/test_grid_cell_locator.sv
module test_grid_cell_locator;
  localparam int W = 150;
  localparam int H = 180;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0, frame_start = 1'b0, pix_valid = 1'b0;
  logic [1023:0] glyph_bank;
  logic [75:0] hl_mask;
  logic pix_on, hl_flag;
  logic [6:0] tile_idx;

  always #5 clk = ~clk;

  grid_cell_locator i_grid_cell_locator (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
    .pix_valid(pix_valid), .glyph_bank(glyph_bank), .hl_mask(hl_mask),
    .pix_on(pix_on), .tile_idx(tile_idx), .hl_flag(hl_flag));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int e1_t = 0, e1_p = 0, e1_h = 0, e2_t = 0, e2_p = 0, e2_h = 0;
  bit e1_cap = 0, e2_cap = 0, e1_v = 0, e2_v = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_glyph(int g, int seed);
    logic [63:0] v;
    for (int b = 0; b < 64; b++) v[b] = ((b * (g + 3) + seed + g) % 5) < 2;
    return v;
  endfunction

  task automatic load(int seed);
    for (int g = 0; g < 16; g++) glyph_bank[g*64 +: 64] = mk_glyph(g, seed);
    for (int i = 0; i < 76; i++) hl_mask[i] = ((i * 7 + seed) % 3) == 0;
  endtask

  // Reference: direct range checks per cell
  task automatic ref_pix(int x, int y, output int t, output int p, output int h, output bit cap);
    t = 0; p = 0; h = 0; cap = 0;
    for (int c = 0; c < 10; c++)
      for (int r = 0; r < 8; r++)
        if (x >= 7 + 13*c && x < 15 + 13*c && y >= 70 + 13*r && y < 78 + 13*r) begin
          t = c*8 + r + 1;
          if (t > 75) begin t = 0; cap = 1; end
          else begin
            p = glyph_bank[(t % 16)*64 + 63 - ((x - 7 - 13*c) + 8*(y - 70 - 13*r))];
            h = hl_mask[t];
          end
        end
  endtask

  task automatic step(bit pv, int x, int y, bit ls, bit fs);
    @(negedge clk);
    if (e2_v) begin
      chk(e2_cap ? "R7 tile" : "R2 R3 R4 tile", int'(tile_idx), e2_t);
      chk(e2_cap ? "R7 pix" : "R5 pix", int'(pix_on), e2_p);
      chk(e2_cap ? "R7 hl" : "R6 hl", int'(hl_flag), e2_h);
    end else begin
      chk("R1 idle tile", int'(tile_idx), 0);
      chk("R1 idle pix", int'(pix_on), 0);
      chk("R1 idle hl", int'(hl_flag), 0);
    end
    e2_t = e1_t; e2_p = e1_p; e2_h = e1_h; e2_cap = e1_cap; e2_v = e1_v;
    e1_v = pv;
    if (pv) ref_pix(x, y, e1_t, e1_p, e1_h, e1_cap);
    else begin e1_t = 0; e1_p = 0; e1_h = 0; e1_cap = 0; end
    pix_valid = pv; line_start = ls; frame_start = fs;
  endtask

  task automatic frame(int seed);
    load(seed);
    for (int y = 0; y < H; y++) begin
      step(0, 0, y, y != 0, y == 0);
      for (int x = 0; x < W; x++) step(1, x, y, 0, 0);
      step(0, 0, y, 0, 0);
      step(0, 0, y, 0, 0);
    end
  endtask

  initial begin
    load(1);
    repeat (3) @(negedge clk);
    chk("R8 reset tile", int'(tile_idx), 0);
    chk("R8 reset pix", int'(pix_on), 0);
    chk("R8 reset hl", int'(hl_flag), 0);
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    frame(1);
    frame(2);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule